// File: doc/BRIEF.md
# Split-History Tree Path Predictor

This block is the second prediction level for a fetch unit that steers through four-path branch trees. A tree holds up to two conditional branches along any one path, so one of four paths (a 2-bit code) is chosen per lookup. The first level supplies the tree's recent outcome history: the last P path codes, 2 bits each, oldest in the most significant pair. The block does not keep one table of four counters indexed by the whole 2P-bit history. It separates the history into two P-bit patterns. One pattern indexes a table that guesses the tree's first branch. The other indexes a second table that guesses the second branch on the chosen path.

Each table holds 2^P single 3-bit saturating counters. The two guessed bits are joined into the path code. The block also returns the speculatively updated history, which the first level writes back. A training port carries two patterns and two resolved branch outcomes, and it adjusts one counter in each table on the same clock edge. When training and lookup touch the same counter in one cycle, the lookup sees the trained value.

Top module: `tree_path_predictor`

## Requirements
- R1: After reset every counter in both tables holds 3, so every history lookup yields path code 2'b00 until training occurs.
- R2: The first-branch pattern bit j equals history bit 2j+1 and the second-branch pattern bit j equals history bit 2j, for j in 0..P-1 (the order from oldest to newest is kept).
- R3: A counter predicts taken (1) when its value is 4 or more, and not taken (0) when it is 0 to 3.
- R4: Training with taken increments the addressed counter and training with not taken decrements it. Both saturate: 7 stays 7 and 0 stays 0.
- R5: The predicted path code has the first-branch guess in bit 1 and the second-branch guess in bit 0.
- R6: The updated history output equals the input history shifted left by two bits, with the predicted path code in bits 1:0.
- R7: When training writes the counter that a lookup reads in the same cycle, the lookup uses the value after the write.
- R8: One training strobe updates the first-branch table at the first pattern and the second-branch table at the second pattern on the same edge, with separate outcomes. Other entries stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hist_i | input | 2P | Tree outcome history, newest code in bits 1:0 |
| pred_path_o | output | 2 | Predicted path code {first, second} |
| hist_next_o | output | 2P | Speculatively updated history |
| trn_en_i | input | 1 | Training strobe |
| trn_hi_pat_i | input | P | Pattern addressing the first-branch table |
| trn_lo_pat_i | input | P | Pattern addressing the second-branch table |
| trn_hi_taken_i | input | 1 | Resolved first-branch outcome |
| trn_lo_taken_i | input | 1 | Resolved second-branch outcome |

## Verification
The bench pushes counters across both saturation ends and then steps them back past the 3/4 boundary. A counter that wraps instead of saturating shows a flipped guess several steps later. A lookup and training aimed at the same counter in one cycle check the forwarding: a design that reads the old value shows the pre-training guess in that cycle. The tests use histories whose odd-bit and even-bit patterns differ, so a swapped or mis-ordered split shows up as a counter trained at one index but predicting at another. The tests also train the two tables in opposite directions in one strobe, which exposes crossed table outputs or a swapped path code.

// File: rtl/tpp_pkg.sv
package tpp_pkg;
    localparam int CTR_W = 3;
    typedef logic [CTR_W-1:0] ctr_t;
    localparam ctr_t CTR_MAX  = ctr_t'((1 << CTR_W) - 1);
    localparam ctr_t CTR_THR  = ctr_t'(1 << (CTR_W - 1));
    localparam ctr_t CTR_INIT = ctr_t'((1 << (CTR_W - 1)) - 1);

    function automatic ctr_t ctr_bump(input ctr_t cur, input logic up);
        if (up)
            return (cur == CTR_MAX) ? cur : ctr_t'(cur + 1'b1);
        else
            return (cur == '0) ? cur : ctr_t'(cur - 1'b1);
    endfunction
endpackage

// File: rtl/tpp_hist_split.sv
module tpp_hist_split #(
    parameter int P = 6
) (
    input  logic [2*P-1:0] hist,
    output logic [P-1:0]   pat_hi,
    output logic [P-1:0]   pat_lo
);
    for (genvar j = 0; j < P; j++) begin : g_bit
        assign pat_hi[j] = hist[2*j+1];
        assign pat_lo[j] = hist[2*j];
    end
endmodule

// File: rtl/tpp_ctr_table.sv
module tpp_ctr_table
    import tpp_pkg::*;
#(
    parameter int P = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [P-1:0] rd_idx,
    output logic         rd_taken,
    input  logic         wr_en,
    input  logic [P-1:0] wr_idx,
    input  logic         wr_up
);
    localparam int DEPTH = 1 << P;

    ctr_t mem [DEPTH];
    ctr_t wr_new;
    ctr_t rd_val;
    logic armed;

    always_comb begin
        wr_new = ctr_bump(mem[wr_idx], wr_up);
        if (wr_en && (wr_idx == rd_idx))
            rd_val = wr_new;
        else
            rd_val = mem[rd_idx];
        rd_taken = (rd_val >= CTR_THR);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= CTR_INIT;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_new;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    AST_SAT_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_up && mem[wr_idx] == CTR_MAX) |=> mem[$past(wr_idx)] == CTR_MAX); // R4
    AST_SAT_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_up && mem[wr_idx] == '0) |=> mem[$past(wr_idx)] == '0); // R4
    AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_up && mem[wr_idx] != CTR_MAX) |=>
        mem[$past(wr_idx)] == ctr_t'($past(mem[wr_idx]) + 1'b1)); // R4
    AST_READ_SEES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> mem[$past(rd_idx)] == $past(rd_val)); // R7
endmodule

// File: rtl/tree_path_predictor.sv
module tree_path_predictor
    import tpp_pkg::*;
#(
    parameter int P = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [2*P-1:0] hist_i,
    output logic [1:0]     pred_path_o,
    output logic [2*P-1:0] hist_next_o,
    input  logic           trn_en_i,
    input  logic [P-1:0]   trn_hi_pat_i,
    input  logic [P-1:0]   trn_lo_pat_i,
    input  logic           trn_hi_taken_i,
    input  logic           trn_lo_taken_i
);
    localparam int HW = 2 * P;

    logic [P-1:0] pat_hi;
    logic [P-1:0] pat_lo;
    logic         guess_hi;
    logic         guess_lo;

    tpp_hist_split #(.P(P)) u_split (
        .hist   (hist_i),
        .pat_hi (pat_hi),
        .pat_lo (pat_lo)
    );

    tpp_ctr_table #(.P(P)) u_first (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (pat_hi),
        .rd_taken (guess_hi),
        .wr_en    (trn_en_i),
        .wr_idx   (trn_hi_pat_i),
        .wr_up    (trn_hi_taken_i)
    );

    tpp_ctr_table #(.P(P)) u_second (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (pat_lo),
        .rd_taken (guess_lo),
        .wr_en    (trn_en_i),
        .wr_idx   (trn_lo_pat_i),
        .wr_up    (trn_lo_taken_i)
    );

    always_comb begin
        pred_path_o = {guess_hi, guess_lo};
        hist_next_o = {hist_i[HW-3:0], guess_hi, guess_lo};
    end

    AST_PATH_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(pred_path_o)); // R5
endmodule

// File: tb/test_tree_path_predictor.sv
module test_tree_path_predictor;
    localparam int P = 6;
    localparam int D = 1 << P;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [2*P-1:0] hist_i = '0;
    logic [1:0]     pred_path_o;
    logic [2*P-1:0] hist_next_o;
    logic           trn_en_i = 1'b0;
    logic [P-1:0]   trn_hi_pat_i = '0;
    logic [P-1:0]   trn_lo_pat_i = '0;
    logic           trn_hi_taken_i = 1'b0;
    logic           trn_lo_taken_i = 1'b0;

    int errors = 0;
    int checks = 0;
    int m1 [D];
    int m2 [D];

    always #2.5 clk = ~clk;

    tree_path_predictor #(.P(P)) i_tree_path_predictor (.*);

    function automatic logic [P-1:0] odd_bits(input logic [2*P-1:0] h);
        logic [P-1:0] r;
        for (int j = 0; j < P; j++) r[j] = h[2*j+1];
        return r;
    endfunction

    function automatic logic [P-1:0] even_bits(input logic [2*P-1:0] h);
        logic [P-1:0] r;
        for (int j = 0; j < P; j++) r[j] = h[2*j];
        return r;
    endfunction

    function automatic int nxt(input int c, input logic up);
        if (up) return (c == 7) ? 7 : c + 1;
        return (c == 0) ? 0 : c - 1;
    endfunction

    // One cycle: drive at negedge, check combinational outputs, model the edge.
    task automatic step(input logic [2*P-1:0] h, input logic en,
                        input logic [P-1:0] a, input logic [P-1:0] b,
                        input logic ta, input logic tb, input string req);
        int c1, c2;
        logic [1:0] ep;
        logic [2*P-1:0] eh;
        @(negedge clk);
        hist_i = h; trn_en_i = en; trn_hi_pat_i = a; trn_lo_pat_i = b;
        trn_hi_taken_i = ta; trn_lo_taken_i = tb;
        #1;
        c1 = m1[odd_bits(h)];
        c2 = m2[even_bits(h)];
        if (en && a == odd_bits(h))  c1 = nxt(m1[a], ta);
        if (en && b == even_bits(h)) c2 = nxt(m2[b], tb);
        ep = {c1 >= 4, c2 >= 4};
        eh = {h[2*P-3:0], ep};
        checks++;
        if (pred_path_o !== ep) begin
            errors++;
            $display("FAIL %s path: actual=%b expected=%b hist=%h", req, pred_path_o, ep, h);
        end
        checks++;
        if (hist_next_o !== eh) begin
            errors++;
            $display("FAIL %s R6 next history: actual=%h expected=%h", req, hist_next_o, eh);
        end
        @(posedge clk);
        if (en) begin
            m1[a] = nxt(m1[a], ta);
            m2[b] = nxt(m2[b], tb);
        end
    endtask

    task automatic t_reset;  // R1, R6
        step(12'h000, 0, 0, 0, 0, 0, "R1 reset");
        step(12'hFFF, 0, 0, 0, 0, 0, "R1 reset");
        step(12'hA5C, 0, 0, 0, 0, 0, "R1 reset");
    endtask

    task automatic t_split;  // R2, R5, R8: opposite training of the two tables
        logic [2*P-1:0] h = 12'b10_00_11_01_10_01; // odd=101010? differs from even
        for (int k = 0; k < 2; k++)
            step(h, 1, odd_bits(h), even_bits(h), 1, 0, "R8 train split");
        step(h, 0, 0, 0, 0, 0, "R2 split lookup");
        step({h[2*P-2:0], 1'b0}, 0, 0, 0, 0, 0, "R2 shifted lookup");
        step(h, 1, odd_bits(h) ^ 6'h01, even_bits(h), 0, 1, "R8 other entry");
        step(h, 0, 0, 0, 0, 0, "R8 untouched entry");
        step(h, 1, 6'h3F ^ odd_bits(h), 6'h3F ^ even_bits(h), 0, 1, "R5 low bit");
        step(12'hFFF ^ h, 0, 0, 0, 0, 0, "R5 low bit lookup");
    endtask

    task automatic t_saturate;  // R3, R4
        logic [2*P-1:0] h = 12'h6C9;
        for (int k = 0; k < 9; k++)
            step(h, 1, odd_bits(h), even_bits(h), 1, 1, "R4 climb");
        for (int k = 0; k < 10; k++)
            step(h, 1, odd_bits(h), even_bits(h), 0, 0, "R3 descend");
        for (int k = 0; k < 4; k++)
            step(h, 1, odd_bits(h), even_bits(h), 1, 0, "R4 floor");
        step(h, 0, 0, 0, 0, 0, "R3 threshold");
    endtask

    task automatic t_bypass;  // R7
        logic [2*P-1:0] h = 12'h3B4;
        step(h, 1, odd_bits(h), even_bits(h), 1, 1, "R7 same-cycle");
        step(h, 1, odd_bits(h), even_bits(h), 0, 0, "R7 same-cycle down");
        step(h, 1, odd_bits(h), even_bits(h), 1, 0, "R7 mixed");
    endtask

    task automatic t_mixed;  // R2, R3, R4, R6 over a pseudo-random sequence
        logic [2*P-1:0] s = 12'h9E1;
        for (int k = 0; k < 300; k++) begin
            s = {s[2*P-2:0], s[11] ^ s[10] ^ s[9] ^ s[3]};
            step(s, s[0] | s[5], s[P-1:0] & 6'h0F, s[2*P-1:P] & 6'h0F,
                 s[7], s[2], "R4 mixed");
        end
    endtask

    initial begin
        for (int i = 0; i < D; i++) begin m1[i] = 3; m2[i] = 3; end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_split();
        t_saturate();
        t_bypass();
        t_mixed();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1000000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule